// File: doc/BRIEF.md
# Clock-Tree Configuration Serial Register Slave

This block is a two-wire serial slave that holds the configuration of a clock generator's output tree. The configuration is seven 8-bit registers. A bus master sets the output enables, the per-output stop controls and a few mode bits with one fixed-format block write. It reads the whole register set back with one block read. The stored bits drive the clock gating logic directly through a flat output vector.

Readback is not a plain echo of the stored bits:
- Two register bytes fold in strap levels that are captured during reset.
- Two bits in register 0 show live pin levels, and one of them is the stored bit ANDed with a pin.
- The last register is a read-only identification byte.

SCL and SDA are sampled on the system clock. The slave never drives SDA high; it only asserts a pull-low enable.

The block uses a fixed block protocol in both directions:
- **Write:** after the address byte, the master sends two filler bytes and then the register data.
- **Read:** the slave first returns a byte count and then the registers in index order.

Top module: `clkcfg_serial_regs`

## Requirements
- R1: The device address is 7'b1101001, so the write address byte is 0xD2 and the read address byte is 0xD3. An address byte carrying any other address gets no ACK (SDA stays released) and changes no register.
- R2: In a write, the slave ACKs the address and every byte that follows. The two bytes after the address are discarded. The bytes after them go to registers 0, 1, 2 and onward in that order.
- R3: In a read, the slave ACKs 0xD3 and then sends, MSB first, a count byte of 0x07 followed by registers 0 to 6. Past register 6 it sends 0x00. A NACK from the master ends the sending, and SDA is released before the stop.
- R4: After reset, the stored bytes 0 to 5 on `ctl_bits` (byte k on bits 8k+7..8k) are 0x08, 0x07, 0x7F, 0xC7, 0x3F and 0x00.
- R5: Register 0 is built as follows:
  - Writable bits are 3, 5 and 7.
  - Readback bits 2..0 are the latched `strap_sel`.
  - Readback bit 3 is stored bit 3 AND `bus_halt_n`.
  - Readback bit 4 is the live `core_halt_n`.
  - Readback bits 5 and 7 are the stored bits.
  - Readback bit 6 is 0.
- R6: Register 1 is built as follows:
  - Bits 5..0 are writable. Bits 2..0 are the pair enables (reset 1) and bits 5..3 are the halt controls (reset 0).
  - Readback bit 6 is 0.
  - Readback bit 7 is the latched `strap_mult`.
- R7: Registers 2, 3, 4 and 5 have write masks 0x7F, 0xFF, 0x3F and 0x0F. Bits outside a mask read 0 and ignore writes.
- R8: Register 6 always reads 0x07: identification nibble 0111 in bits 3..0 and revision 0000 in bits 7..4. Writes to it have no effect.
- R9: A stop before register 6 keeps every register byte already received. Data bytes past register 6 are ACKed and discarded.
- R10: `strap_sel` and `strap_mult` are captured while `rst` is high. Later changes on these pins do not show in readback.
- R11: The slave pulls SDA low only in the ACK slot of a byte it accepts, or while it sends a data bit. Every stop releases SDA.
- R12: `ctl_bits` changes only in the cycle after a data byte bound for a register is completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | Pull-low enable for the open-drain SDA driver |
| strap_sel | input | 3 | Frequency-select strap levels |
| strap_mult | input | 1 | Current-multiplier strap level |
| bus_halt_n | input | 1 | Active-low peripheral-clock stop pin |
| core_halt_n | input | 1 | Active-low processor-clock stop pin |
| ctl_bits | output | 48 | Stored registers 0 to 5, byte k on bits 8k+7..8k |

## Verification
The checker asserts the following on every clock cycle:
- The slave drives SDA only while it owns the line.
- A stop or a rejected address releases SDA.
- A commit always targets a register that exists.
- The stored vector moves only on a commit.
- The stored vector holds the reset image right after reset.

Only the bench's scenarios can show the rest. This covers the masked merge per register and the composition of register 0 and register 1 from straps and live pins. It also covers the count prefix, the ordering of bytes on both directions, early stops, surplus bytes and strap latching. The bench reaches each of these by decoding a full transaction against its own register model.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  // Identification byte: vendor nibble 0111, revision 0000.
  localparam logic [7:0] ID_BYTE = 8'h07;

  // Bits of stored register idx that a write may change.
  function automatic logic [7:0] wr_mask(input int unsigned idx);
    case (idx)
      0:       return 8'hA8;
      1:       return 8'h3F;
      2:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h3F;
      5:       return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int unsigned idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] merge_wr(input logic [7:0] old_v,
                                          input logic [7:0] new_v,
                                          input logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm #(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned NUM_REGS    = 7,
  parameter int unsigned DUMMY_BYTES = 2,
  parameter int unsigned IDX_W       = 3,
  localparam int unsigned CNT_MAX    = DUMMY_BYTES + NUM_REGS + 1,
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_commit,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             addr_reject,
  output logic             owns_line,
  output logic             sda_low
);
  typedef enum logic [2:0] {ST_IDLE, ST_RECV, ST_ACK_OUT, ST_SEND, ST_ACK_IN} tw_state_e;

  tw_state_e        state;
  logic [2:0]       bit_cnt;
  logic [6:0]       shreg;
  logic [6:0]       tx;
  logic             is_addr, rd_mode, ack_due;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       rx_byte, tx_next;
  logic             byte_end, in_reg_window;

  assign rx_byte       = {shreg, sda_s};
  assign byte_end      = (state == ST_RECV) && scl_rise && (bit_cnt == 3'd7);
  assign in_reg_window = (byte_cnt >= CNT_W'(DUMMY_BYTES)) &&
                         (byte_cnt <  CNT_W'(DUMMY_BYTES + NUM_REGS));
  assign wr_commit     = byte_end && !is_addr && !rd_mode && in_reg_window;
  assign wr_idx        = IDX_W'(byte_cnt - CNT_W'(DUMMY_BYTES));
  assign wr_data       = rx_byte;
  assign addr_reject   = byte_end && is_addr && (rx_byte[7:1] != DEV_ADDR);
  assign owns_line     = (state == ST_ACK_OUT) || (state == ST_SEND);
  assign rd_idx        = IDX_W'(byte_cnt - CNT_W'(1));

  // Outgoing byte: count prefix, then registers, then zero fill.
  always_comb begin
    if (byte_cnt == '0)                      tx_next = 8'(NUM_REGS);
    else if (byte_cnt <= CNT_W'(NUM_REGS))   tx_next = rd_data;
    else                                     tx_next = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      ack_due  <= 1'b0;
      byte_cnt <= '0;
      sda_low  <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_RECV;
      bit_cnt <= '0;
      is_addr <= 1'b1;
      rd_mode <= 1'b0;
      ack_due <= 1'b0;
      sda_low <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      ack_due <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (scl_rise) begin
            shreg   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (is_addr) begin
                is_addr <= 1'b0;
                if (addr_reject) state <= ST_IDLE;
                else begin
                  ack_due  <= 1'b1;
                  rd_mode  <= rx_byte[0];
                  byte_cnt <= '0;
                end
              end else begin
                ack_due <= 1'b1;
                if (byte_cnt != CNT_W'(CNT_MAX)) byte_cnt <= byte_cnt + CNT_W'(1);
              end
            end
          end else if (scl_fall && ack_due) begin
            ack_due <= 1'b0;
            sda_low <= 1'b1;
            state   <= ST_ACK_OUT;
          end
        end
        ST_ACK_OUT: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx      <= tx_next[6:0];
              sda_low <= ~tx_next[7];
              state   <= ST_SEND;
              if (byte_cnt != CNT_W'(CNT_MAX)) byte_cnt <= byte_cnt + CNT_W'(1);
            end else begin
              sda_low <= 1'b0;
              state   <= ST_RECV;
            end
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_low <= 1'b0;
              state   <= ST_ACK_IN;
            end else begin
              sda_low <= ~tx[6];
              tx      <= {tx[5:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        ST_ACK_IN: begin
          if (scl_rise) begin
            if (sda_s) state <= ST_IDLE;
            else       ack_due <= 1'b1;
          end else if (scl_fall && ack_due) begin
            ack_due <= 1'b0;
            bit_cnt <= '0;
            tx      <= tx_next[6:0];
            sda_low <= ~tx_next[7];
            state   <= ST_SEND;
            if (byte_cnt != CNT_W'(CNT_MAX)) byte_cnt <= byte_cnt + CNT_W'(1);
          end
        end
        default: sda_low <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3,
  localparam int unsigned NSTORE  = NUM_REGS - 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic [2:0]            strap_sel,
  input  logic                  strap_mult,
  input  logic                  bus_halt_n,
  input  logic                  core_halt_n,
  output logic [7:0]            rd_data,
  output logic [8*NSTORE-1:0]   ctl_bits
);
  logic [7:0] stor [NSTORE];
  logic [2:0] sel_q;
  logic       mult_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= strap_sel;
      mult_q <= strap_mult;
    end
  end

  for (genvar g = 0; g < NSTORE; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        stor[g] <= rst_val(g);
      else if (wr_en && (wr_idx == IDX_W'(g)))
        stor[g] <= merge_wr(stor[g], wr_data, wr_mask(g));
    end
    assign ctl_bits[8*g +: 8] = stor[g];
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx == IDX_W'(0))
      rd_data = {stor[0][7], 1'b0, stor[0][5], core_halt_n,
                 stor[0][3] & bus_halt_n, sel_q};
    else if (rd_idx == IDX_W'(1))
      rd_data = {mult_q, 1'b0, stor[1][5:0]};
    else if (rd_idx == IDX_W'(NSTORE))
      rd_data = ID_BYTE;
    else if (int'(rd_idx) < NSTORE)
      rd_data = stor[rd_idx];
  end
endmodule

// File: rtl/clkcfg_serial_regs.sv
module clkcfg_serial_regs #(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned NUM_REGS    = 7,
  parameter int unsigned DUMMY_BYTES = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS + 1),
  localparam int unsigned CTL_W      = 8 * (NUM_REGS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_drive_low,
  input  logic [2:0]       strap_sel,
  input  logic             strap_mult,
  input  logic             bus_halt_n,
  input  logic             core_halt_n,
  output logic [CTL_W-1:0] ctl_bits
);
  logic             sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_commit, addr_reject, owns_line;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tw_slave_fsm #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS),
    .DUMMY_BYTES(DUMMY_BYTES), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_commit(wr_commit), .wr_idx(wr_idx), .wr_data(wr_data),
    .addr_reject(addr_reject), .owns_line(owns_line), .sda_low(sda_drive_low)
  );

  cfg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_commit), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .strap_sel(strap_sel), .strap_mult(strap_mult),
    .bus_halt_n(bus_halt_n), .core_halt_n(core_halt_n),
    .rd_data(rd_data), .ctl_bits(ctl_bits)
  );
endmodule

// File: rtl/clkcfg_serial_regs_chk.sv
module clkcfg_serial_regs_chk
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3,
  localparam int unsigned CTL_W   = 8 * (NUM_REGS - 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_drive_low,
  input logic             owns_line,
  input logic             stop_evt,
  input logic             addr_reject,
  input logic             wr_commit,
  input logic [IDX_W-1:0] wr_idx,
  input logic [CTL_W-1:0] ctl_bits
);
  function automatic logic [CTL_W-1:0] reset_image();
    logic [CTL_W-1:0] v;
    for (int i = 0; i < NUM_REGS - 1; i++) v[8*i +: 8] = rst_val(i);
    return v;
  endfunction

  // R11: SDA is pulled only while the slave owns the line
  a_r11_drive_when_owned: assert property (@(posedge clk) disable iff (rst)
    sda_drive_low |-> owns_line);

  // R11: a stop always leaves SDA released
  a_r11_release_on_stop: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_drive_low);

  // R1: a foreign address is never acknowledged
  a_r1_reject_silent: assert property (@(posedge clk) disable iff (rst)
    addr_reject |=> !sda_drive_low);

  // R2: commits address an existing register
  a_r2_commit_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (int'(wr_idx) < NUM_REGS));

  // R12: stored state moves only on a commit
  a_r12_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
    !wr_commit |=> $stable(ctl_bits));

  // R4: reset image visible right after reset
  a_r4_reset_image: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl_bits == reset_image()));
endmodule

bind clkcfg_serial_regs clkcfg_serial_regs_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .sda_drive_low(sda_drive_low), .owns_line(owns_line),
  .stop_evt(stop_evt), .addr_reject(addr_reject), .wr_commit(wr_commit),
  .wr_idx(wr_idx), .ctl_bits(ctl_bits)
);

// File: tb/clkcfg_serial_regs_test.sv
`timescale 1ns/1ps
module clkcfg_serial_regs_test;
  localparam int H = 6;
  localparam logic [2:0] SEL_LATCH = 3'b101;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0]  strap_sel = SEL_LATCH;
  logic        strap_mult = 1'b1;
  logic        bus_n = 1'b1, core_n = 1'b1;
  logic        sda_drive_low;
  logic [47:0] ctl_bits;
  logic        sda_line;
  logic        in_flux = 1'b1;
  logic        done = 1'b0;

  assign sda_line = m_sda & ~sda_drive_low;

  clkcfg_serial_regs uut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .strap_sel(strap_sel), .strap_mult(strap_mult),
    .bus_halt_n(bus_n), .core_halt_n(core_n), .ctl_bits(ctl_bits)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mdl [6];
  logic [7:0] wbuf [12];
  localparam logic [7:0] MSK [6] = '{8'hA8, 8'h3F, 8'h7F, 8'hFF, 8'h3F, 8'h0F};
  localparam logic [7:0] RSV [6] = '{8'h08, 8'h07, 8'h7F, 8'hC7, 8'h3F, 8'h00};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    case (k)
      0: return {mdl[0][7], 1'b0, mdl[0][5], core_n, mdl[0][3] & bus_n, SEL_LATCH};
      1: return {1'b1, 1'b0, mdl[1][5:0]};
      2, 3, 4, 5: return mdl[k];
      6: return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  // Per-cycle comparison of the stored vector against the model (R4, R7, R12)
  always @(negedge clk) begin
    if (!rst && !in_flux && !done) begin
      n_cmp++;
      if (ctl_bits !== {mdl[5], mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]}) begin
        n_bad++;
        $display("FAIL R12 ctl_bits: got %012h expected %012h", ctl_bits,
                 {mdl[5], mdl[4], mdl[3], mdl[2], mdl[1], mdl[0]});
      end
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; half();
    m_sda = 1'b0; half();
    m_scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; half();
    m_scl = 1'b1; half();
    m_sda = 1'b1; half();
  endtask

  // Sends a byte; the model register reg_idx (if 0..5) takes the write during the ACK slot.
  task automatic put_byte(input logic [7:0] b, input int reg_idx, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; half();
      if (i == 0) in_flux = 1'b1;
      m_scl = 1'b1; half();
      m_scl = 1'b0;
    end
    m_sda = 1'b1; half();
    m_scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = sda_line;
    if (reg_idx >= 0 && reg_idx < 6)
      mdl[reg_idx] = (mdl[reg_idx] & ~MSK[reg_idx]) | (b & MSK[reg_idx]);
    in_flux = 1'b0;
    repeat (H - H/2) @(negedge clk);
    m_scl = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half();
      m_scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H - H/2) @(negedge clk);
      m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; half();
    m_scl = 1'b1; half();
    m_scl = 1'b0; m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] dev, input int n, input string tag);
    logic ack;
    bus_start();
    put_byte({dev, 1'b0}, -1, ack);
    if (dev != 7'h69) begin
      chk({tag, " R1 foreign address not acked"}, {7'b0, ack}, 8'h01);
      bus_stop();
      return;
    end
    chk({tag, " R1 address ack"}, {7'b0, ack}, 8'h00);
    put_byte(8'h5A, -1, ack); chk({tag, " R2 filler ack"}, {7'b0, ack}, 8'h00);
    put_byte(8'hC3, -1, ack); chk({tag, " R2 filler ack"}, {7'b0, ack}, 8'h00);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], (i < 6) ? i : -1, ack);
      chk({tag, (i > 6) ? " R9 surplus ack" : " R2 data ack"}, {7'b0, ack}, 8'h00);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    put_byte(8'hD3, -1, ack);
    chk({tag, " R1 read address ack"}, {7'b0, ack}, 8'h00);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, b);
      if (k == 0) chk({tag, " R3 count byte"}, b, 8'h07);
      else        chk($sformatf("%s R3 R5 R6 R7 R8 reg%0d", tag, k - 1), b, exp_rd(k - 1));
    end
    repeat (4) @(negedge clk);
    chk({tag, " R3 released after nack"}, {7'b0, sda_drive_low}, 8'h00);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 6; i++) mdl[i] = RSV[i];
    repeat (10) @(negedge clk);
    rst = 1'b0;
    in_flux = 1'b0;
    // R10: strap pins change after reset
    strap_sel = 3'b010; strap_mult = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 reset byte0", ctl_bits[7:0], 8'h08);
    chk("R4 reset byte3", ctl_bits[31:24], 8'hC7);
    chk("R11 idle release", {7'b0, sda_drive_low}, 8'h00);
    rd_txn(8, "reset R10 R4");

    for (int i = 0; i < 7; i++) wbuf[i] = 8'hFF;
    wr_txn(7'h69, 7, "ones R7 R8");
    rd_txn(8, "ones");

    for (int i = 0; i < 7; i++) wbuf[i] = 8'h00;
    wr_txn(7'h69, 7, "zeros");
    rd_txn(8, "zeros");

    // R9 early stop keeps received registers
    wbuf[0] = 8'h28; wbuf[1] = 8'h15; wbuf[2] = 8'h55;
    wr_txn(7'h69, 3, "early R9");
    rd_txn(8, "early R9");

    // R9 surplus bytes ignored
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h11 * (i + 1));
    wr_txn(7'h69, 9, "surplus R9");
    rd_txn(10, "surplus R3");

    // R1 foreign address leaves state untouched
    wr_txn(7'h48, 0, "foreign R1");
    rd_txn(3, "foreign R1");

    // R5 live pins
    wbuf[0] = 8'hFF;
    wr_txn(7'h69, 1, "pins R5");
    bus_n = 1'b0; core_n = 1'b0;
    rd_txn(2, "pins low R5");
    bus_n = 1'b1; core_n = 1'b0;
    rd_txn(2, "pins mixed R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule